// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Receiver

This block takes in bytes over a two-wire synchronous link: one serial clock line and one serial data line. It can make the serial clock itself from the system clock through a power-of-two divider, or it can follow a clock that a remote device drives. Data bits are taken on each rising edge of the serial clock, least significant bit first. Eight bits make a byte, which moves from the shift register into a holding register and raises a ready flag for the host.

The host polls the ready flag and takes the byte with a one-cycle read strobe, which clears the flag. The receive path is double-buffered: a new byte can shift in while the previous one waits. If a byte finishes while the old one has not been read, an overrun flag is raised and the old byte is kept. When the block makes the clock, a stop request lets the byte in flight finish and then holds the clock line high.

Top module: `sync_byte_rx`

## Requirements
- R1: After reset, and in every cycle after `en` has been low for one cycle, `rx_ready` and `rx_ovr` are 0 and `ser_clk_o` is 1. After reset `rx_data` is 0.
- R2: Bits are taken least significant first. The bit seen at the first rising serial clock edge of a byte lands in `rx_data[0]` and the eighth lands in `rx_data[7]`.
- R3: On the eighth rising edge of a byte, with `rx_ready` and `rx_ovr` both 0, the byte is copied to `rx_data` and `rx_ready` goes to 1.
- R4: A `host_rd` pulse clears `rx_ready` in the next cycle. If the pulse falls in the same cycle as a byte completion, the new byte is loaded and `rx_ready` stays 1 with no overrun.
- R5: If the eighth rising edge of a byte comes while `rx_ready` is 1 and no read is made in that cycle, `rx_ovr` goes to 1 and `rx_data` keeps the earlier byte.
- R6: `rx_ovr` stays set until an `ovr_clr` pulse. While it is set, every completed byte is discarded, even when `rx_ready` is 0. If a new overrun arrives in the same cycle as `ovr_clr`, the set wins.
- R7: With `master_sel`=1, the block drives `ser_clk_o` with a high phase and a low phase of 2^`rate_sel` system cycles each. The clock starts from its high idle level and falls first.
- R8: In master mode the clock runs without a break from one byte to the next. Bytes are received in order as long as the host reads each one.
- R9: When `stop_req` is 1 in master mode, the byte in progress completes and `ser_clk_o` then stays 1 with no further falling edge.
- R10: With `master_sel`=0, bits are taken on rising edges of `ser_clk_i` after a synchronizer of `SYNC_STAGES` flops (default 2), and `ser_clk_o` stays 1.
- R11: Clearing `en` in the middle of a byte drops the partial bits. The first byte received after `en` returns is whole and correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears the bit count and both flags |
| master_sel | input | 1 | 1: block drives the serial clock; 0: external clock |
| rate_sel | input | RATE_W | Master clock phase length exponent (2^rate_sel cycles) |
| stop_req | input | 1 | Master mode: finish the current byte, then park the clock high |
| ser_clk_i | input | 1 | External serial clock (slave mode) |
| ser_dat_i | input | 1 | Serial data line |
| ser_clk_o | output | 1 | Generated serial clock, high when idle |
| host_rd | input | 1 | One-cycle read strobe; clears rx_ready |
| rx_data | output | DATA_W | Receive holding register |
| rx_ready | output | 1 | A byte is waiting in rx_data |
| rx_ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | One-cycle pulse that clears rx_ovr |

## Verification
Two functions can land in the same system cycle here: the host read that frees the holding register, and the completion of the next byte. The bench counts the synchronizer stages from the last rising edge of `ser_clk_i` and places `host_rd` exactly in the completion cycle. It then expects the new byte in `rx_data`, `rx_ready` still at 1 and `rx_ovr` at 0, where a read one cycle late would have produced an overrun. The overrun sequence also checks that the old byte survives repeated completions and that a byte completed while the flag is set is dropped even with the buffer empty.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
   // largest supported rate field width; keeps the divider counter at most 32 bits
   localparam int SBR_MAX_RATE_W = 5;

   // source of the bit-sampling edge
   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } clk_src_e;
endpackage

// File: rtl/sbr_sync.sv
`timescale 1ns/1ps
module sbr_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sbr_clkgen.sv
`timescale 1ns/1ps
module sbr_clkgen #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              stop_req,
   input  logic              at_boundary,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              clk_o,
   output logic              rise_tick
);
   localparam int DIV_W = 1 << RATE_W;

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] half_m1;
   logic             park;
   logic             wrap;

   assign half_m1   = (DIV_W'(1) << rate_sel) - DIV_W'(1);
   assign park      = clk_o && at_boundary && stop_req;
   assign wrap      = (div_cnt == half_m1);
   assign rise_tick = run && !park && wrap && !clk_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_o   <= 1'b1;
         div_cnt <= '0;
      end else if (!run || park) begin
         clk_o   <= 1'b1;
         div_cnt <= '0;
      end else if (wrap) begin
         clk_o   <= ~clk_o;
         div_cnt <= '0;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sbr_shifter.sv
`timescale 1ns/1ps
module sbr_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              bit_in,
   input  logic              host_rd,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] hold,
   output logic              ready,
   output logic              ovr,
   output logic              at_boundary,
   output logic              done
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] next_word;
   logic [CNT_W-1:0]  cnt;
   logic              blocked;

   assign next_word   = {bit_in, shreg[DATA_W-1:1]};
   assign done        = tick && (cnt == LAST);
   assign blocked     = ovr || (ready && !host_rd);
   assign at_boundary = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
         hold  <= '0;
         ready <= 1'b0;
         ovr   <= 1'b0;
      end else if (!en) begin
         shreg <= '0;
         cnt   <= '0;
         ready <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         if (tick) begin
            shreg <= next_word;
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
         if (done && !blocked) begin
            hold  <= next_word;
            ready <= 1'b1;
         end else if (host_rd) begin
            ready <= 1'b0;
         end
         if (done && blocked) ovr <= 1'b1;
         else if (ovr_clr)    ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/sync_byte_rx.sv
`timescale 1ns/1ps
module sync_byte_rx
   import sbr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RATE_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MASTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master_sel,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              stop_req,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   output logic              ser_clk_o,
   input  logic              host_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              rx_ovr,
   input  logic              ovr_clr
);
   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sync_byte_rx: SYNC_STAGES must be at least 2");
   end
   if (RATE_W < 1 || RATE_W > SBR_MAX_RATE_W) begin : g_bad_rate
      $error("sync_byte_rx: RATE_W out of range");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("sync_byte_rx: DATA_W must be at least 2");
   end

   clk_src_e   src;
   logic [1:0] sync_q;
   logic       s_clk, s_dat, s_clk_q;
   logic       slv_rise, mst_rise, tick;
   logic       at_boundary_w, done_w;

   assign src = (MASTER_EN && master_sel) ? SRC_INTERNAL : SRC_EXTERNAL;

   sbr_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (2),
      .RST_VAL(2'b11)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_clk_i, ser_dat_i}),
      .q    (sync_q)
   );

   assign s_clk = sync_q[1];
   assign s_dat = sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_clk_q <= 1'b1;
      else        s_clk_q <= s_clk;
   end

   assign slv_rise = s_clk && !s_clk_q;

   if (MASTER_EN) begin : g_master
      sbr_clkgen #(.RATE_W(RATE_W)) i_clkgen (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (en && (src == SRC_INTERNAL)),
         .stop_req   (stop_req),
         .at_boundary(at_boundary_w),
         .rate_sel   (rate_sel),
         .clk_o      (ser_clk_o),
         .rise_tick  (mst_rise)
      );
   end else begin : g_slave_only
      assign ser_clk_o = 1'b1;
      assign mst_rise  = 1'b0;
   end

   assign tick = (src == SRC_INTERNAL) ? mst_rise : slv_rise;

   sbr_shifter #(.DATA_W(DATA_W)) i_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .tick       (tick),
      .bit_in     (s_dat),
      .host_rd    (host_rd),
      .ovr_clr    (ovr_clr),
      .hold       (rx_data),
      .ready      (rx_ready),
      .ovr        (rx_ovr),
      .at_boundary(at_boundary_w),
      .done       (done_w)
   );
endmodule

// File: rtl/sbr_checker.sv
`timescale 1ns/1ps
module sbr_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              master_sel,
   input logic              host_rd,
   input logic              ovr_clr,
   input logic              ser_clk_o,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              rx_ovr,
   input logic              done
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (ser_clk_o && !rx_ready && !rx_ovr));

   p_done_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en && !rx_ovr) |=> rx_ready);

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !done) |=> !rx_ready);

   p_keep_old_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_ovr) |-> $stable(rx_data));

   p_ovr_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> $past(rx_ready));

   p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr && en && !ovr_clr) |=> rx_ovr);

   p_slave_clk_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |=> ser_clk_o);
endmodule

bind sync_byte_rx sbr_checker #(.DATA_W(DATA_W)) i_sbr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .master_sel(master_sel),
   .host_rd   (host_rd),
   .ovr_clr   (ovr_clr),
   .ser_clk_o (ser_clk_o),
   .rx_data   (rx_data),
   .rx_ready  (rx_ready),
   .rx_ovr    (rx_ovr),
   .done      (done_w)
);

// File: tb/test_sync_byte_rx.sv
`timescale 1ns/1ps
module test_sync_byte_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, master_sel = 1'b0, stop_req = 1'b0;
   logic [3:0] rate_sel = '0;
   logic       ser_clk_i = 1'b1, ser_dat_i = 1'b1;
   logic       ser_clk_o;
   logic       host_rd = 1'b0, ovr_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, rx_ovr;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // master-mode data driver: next bit appears after each falling edge
   logic [7:0] drv_q [4];
   int         drv_idx = 32;

   // {master, rate, data}
   localparam logic [12:0] VEC [6] = '{
      {1'b0, 4'd0, 8'hA5}, {1'b0, 4'd0, 8'h01}, {1'b0, 4'd0, 8'h80},
      {1'b1, 4'd2, 8'h96}, {1'b1, 4'd3, 8'h5A}, {1'b1, 4'd4, 8'hC3}
   };

   always #4 clk = ~clk;

   sync_byte_rx i_sync_byte_rx (
      .clk(clk), .rst_n(rst_n), .en(en), .master_sel(master_sel),
      .rate_sel(rate_sel), .stop_req(stop_req), .ser_clk_i(ser_clk_i),
      .ser_dat_i(ser_dat_i), .ser_clk_o(ser_clk_o), .host_rd(host_rd),
      .rx_data(rx_data), .rx_ready(rx_ready), .rx_ovr(rx_ovr), .ovr_clr(ovr_clr)
   );

   always @(negedge ser_clk_o) begin
      if (drv_idx < 32) begin
         ser_dat_i = drv_q[drv_idx / 8][drv_idx % 8];
         drv_idx++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_pulse();
      host_rd = 1'b1; cyc(1); host_rd = 1'b0; cyc(1);
   endtask

   task automatic slave_bits(input logic [7:0] b, input int nbits, input bit rd_on_last);
      for (int i = 0; i < nbits; i++) begin
         ser_clk_i = 1'b0; ser_dat_i = b[i]; cyc(4);
         ser_clk_i = 1'b1;
         if (i == 7 && rd_on_last) begin
            // rise seen after 2 sync flops; completion lands at the 3rd edge
            cyc(2); host_rd = 1'b1; cyc(1); host_rd = 1'b0; cyc(1);
         end else begin
            cyc(4);
         end
      end
   endtask

   task automatic wait_ready(input int max);
      int n = 0;
      while (!rx_ready && n < max) begin cyc(1); n++; end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      time t0, t1;
      bit parked;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1: reset state
      check("R1 reset ready", rx_ready, 0);
      check("R1 reset ovr", rx_ovr, 0);
      check("R1 reset clk idle", ser_clk_o, 1);
      check("R1 reset data", rx_data, 0);
      en = 1'b1; cyc(2);

      // vector table: slave bytes, and single master bytes ended by stop
      foreach (VEC[k]) begin
         logic [7:0] b;
         b = VEC[k][7:0];
         if (!VEC[k][12]) begin
            slave_bits(b, 8, 0);
            check("R2 R3 R10 slave byte", rx_data, b);
            check("R3 slave ready", rx_ready, 1);
            check("R10 clk out idle in slave", ser_clk_o, 1);
         end else begin
            drv_q[0] = b; drv_idx = 0;
            rate_sel = VEC[k][11:8]; master_sel = 1'b1;
            @(negedge ser_clk_o); t0 = $time;
            cyc(1); stop_req = 1'b1;
            @(posedge ser_clk_o); t1 = $time;
            check("R7 half period", 32'(t1 - t0), 32'(8 * (1 << VEC[k][11:8])));
            wait_ready(4000);
            check("R2 R3 master byte", rx_data, b);
            check("R3 master ready", rx_ready, 1);
            parked = 1;
            for (int j = 0; j < 4 * (1 << VEC[k][11:8]); j++) begin
               cyc(1);
               if (ser_clk_o !== 1'b1) parked = 0;
            end
            check("R9 clock parked high", parked, 1);
            check("R9 one byte only", drv_idx, 8);
            master_sel = 1'b0; stop_req = 1'b0;
         end
         check("R3 no overrun", rx_ovr, 0);
         rd_pulse();
         check("R4 read clears ready", rx_ready, 0);
      end

      // R5 / R6: overrun in slave mode
      slave_bits(8'h11, 8, 0);
      slave_bits(8'h22, 8, 0);
      check("R5 overrun set", rx_ovr, 1);
      check("R5 old byte kept", rx_data, 8'h11);
      check("R5 ready still set", rx_ready, 1);
      slave_bits(8'h33, 8, 0);
      check("R6 sticky, byte dropped", rx_data, 8'h11);
      rd_pulse();
      check("R4 read clears ready", rx_ready, 0);
      slave_bits(8'h44, 8, 0);
      check("R6 discard with empty buffer data", rx_data, 8'h11);
      check("R6 discard with empty buffer ready", rx_ready, 0);
      check("R6 flag still set", rx_ovr, 1);
      ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0; cyc(1);
      check("R6 ovr_clr clears", rx_ovr, 0);
      slave_bits(8'h55, 8, 0);
      check("R6 reception resumes", rx_data, 8'h55);

      // R4: read in the completion cycle
      slave_bits(8'h66, 8, 1);
      check("R4 coincident read loads new", rx_data, 8'h66);
      check("R4 coincident read keeps ready", rx_ready, 1);
      check("R4 coincident read no overrun", rx_ovr, 0);
      rd_pulse();

      // R11 / R1: enable clear mid-byte with flags set
      slave_bits(8'h77, 8, 0);
      slave_bits(8'h88, 8, 0);
      slave_bits(8'hFF, 3, 0);
      en = 1'b0; cyc(2);
      check("R1 disable clears ready", rx_ready, 0);
      check("R1 disable clears ovr", rx_ovr, 0);
      en = 1'b1; cyc(2);
      slave_bits(8'h3C, 8, 0);
      check("R11 fresh byte after enable", rx_data, 8'h3C);
      check("R11 ready after enable", rx_ready, 1);
      rd_pulse();

      // R8 / R9: continuous master reception with stop on third byte
      drv_q[0] = 8'hD2; drv_q[1] = 8'h4B; drv_q[2] = 8'hE1; drv_q[3] = 8'h0F;
      drv_idx = 0; rate_sel = 4'd2; master_sel = 1'b1;
      for (int k = 0; k < 3; k++) begin
         wait_ready(4000);
         check("R8 continuous byte", rx_data, drv_q[k]);
         check("R8 no overrun", rx_ovr, 0);
         rd_pulse();
         if (k == 1) begin
            @(negedge ser_clk_o); cyc(1); stop_req = 1'b1;
         end
      end
      cyc(200);
      check("R9 no fourth byte ready", rx_ready, 0);
      check("R9 no fourth byte bits", drv_idx, 24);
      check("R9 parked high", ser_clk_o, 1);
      stop_req = 1'b0; master_sel = 1'b0; cyc(2);

      // R1: disable during master run returns clock high
      drv_q[0] = 8'hFF; drv_idx = 0; rate_sel = 4'd3; master_sel = 1'b1;
      @(negedge ser_clk_o); cyc(3);
      en = 1'b0; cyc(2);
      check("R1 disable parks clock", ser_clk_o, 1);
      check("R1 disable no ready", rx_ready, 0);
      master_sel = 1'b0; en = 1'b1; drv_idx = 32; cyc(2);
      slave_bits(8'hA9, 8, 0);
      check("R11 slave byte after master abort", rx_data, 8'hA9);

      finish_run();
   end
endmodule